// File: doc/BRIEF.md
# Multi-CPU Interrupt Wake Notifier

When a new interrupt of some class becomes pending somewhere in the system, this block decides which processors must be told about it. A notify strobe arrives with a one-hot class vector (service, I/O, machine check). Every processor then gets a sticky "hard interrupt requested" flag. The flag stays set until that processor acknowledges it. The block also decides, per processor, whether to send a one-cycle kick pulse that wakes it or makes it look at its interrupt state.

Processors that are running are always kicked. Processors that are stopped or in check-stop get the flag but no kick. A halted processor is kicked only if it has enabled the class that decides the notification. When more than one class bit is set, that class is the highest-priority one present, in the order service, I/O, machine check. Choosing which processor finally takes the interrupt is left to the processors.

Top module: `irq_wake_notifier`

## Requirements
- R1: After reset, all request flags are 0 and no kick pulse is driven.
- R2: In the cycle after a notify strobe, every processor's request flag reads 1, whatever its run state or halted flag.
- R3: A request flag stays 1 until the acknowledge of that processor is asserted, and then reads 0 in the following cycle. An acknowledge in the same cycle as a notify wins, so the flag reads 0.
- R4: Run state codes are 0 stopped, 1 check-stop, 2 operating, 3 load. A processor in state 0 or 1 never gets a kick pulse.
- R5: A processor in state 2 or 3 that is not halted gets a kick pulse, whatever its enable bits.
- R6: A halted processor in state 2 or 3 is kicked for the service class (class bit 0) only if its external enable is set.
- R7: A halted processor in state 2 or 3 is kicked for the I/O class (class bit 1) only if its I/O enable is set. It is kicked for the machine-check class (class bit 2) only if its machine-check enable is set.
- R8: If several class bits are set, only the first one in the order bit 0, bit 1, bit 2 decides the filter for halted processors. Any other set bits are ignored.
- R9: A kick pulse is one cycle long. It appears in the cycle after the notify strobe, and only when a strobe came in the cycle before.
- R10: A notify with an all-zero class vector sets the request flags and kicks running, non-halted processors. It kicks no halted processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| notify_i | input | 1 | Notify strobe, one cycle |
| class_i | input | 3 | Class vector: bit0 service, bit1 I/O, bit2 machine check |
| run_state_i | input | 2*NUM_CPU | Per-processor run state code, 2 bits each |
| halted_i | input | NUM_CPU | Per-processor halted flag |
| en_ext_i | input | NUM_CPU | Per-processor external interrupt enable |
| en_io_i | input | NUM_CPU | Per-processor I/O interrupt enable |
| en_mchk_i | input | NUM_CPU | Per-processor machine-check enable |
| ack_i | input | NUM_CPU | Per-processor acknowledge, clears the request flag |
| irq_req_o | output | NUM_CPU | Sticky hard interrupt request flags |
| kick_o | output | NUM_CPU | One-cycle kick pulses |

## Verification
The bench uses the default NUM_CPU of 4. This is enough to give each processor a different run state in a single notify, so all four state codes are seen side by side in the same cycle. It also lets the halted processors carry different enable bits, so that one notify both passes and blocks kicks. With four processors, acknowledges can be applied to some processors while the others keep their flags, and an acknowledge can meet a notify in the same cycle.

// File: rtl/irq_wake_pkg.sv
package irq_wake_pkg;
  localparam int unsigned NUM_CLASS = 3;

  typedef enum logic [1:0] {
    RS_STOPPED   = 2'd0,
    RS_CHECKSTOP = 2'd1,
    RS_OPERATING = 2'd2,
    RS_LOAD      = 2'd3
  } run_state_e;

  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_SERV = 2'd1,
    CL_IO   = 2'd2,
    CL_MCHK = 2'd3
  } win_class_e;
endpackage

// File: rtl/irq_class_prio.sv
module irq_class_prio
  import irq_wake_pkg::*;
(
  input  logic [NUM_CLASS-1:0] class_i,
  output win_class_e           win_o
);
  always_comb begin
    if (class_i[0])      win_o = CL_SERV;
    else if (class_i[1]) win_o = CL_IO;
    else if (class_i[2]) win_o = CL_MCHK;
    else                 win_o = CL_NONE;
  end

  // R8
  always_comb begin
    if (class_i[0]) winner_serv_chk: assert (win_o == CL_SERV);
  end
endmodule

// File: rtl/irq_cpu_filter.sv
module irq_cpu_filter
  import irq_wake_pkg::*;
(
  input  win_class_e win_i,
  input  logic [1:0] run_state_i,
  input  logic       halted_i,
  input  logic       en_ext_i,
  input  logic       en_io_i,
  input  logic       en_mchk_i,
  output logic       kick_o
);
  logic active;
  logic enabled;

  assign active = (run_state_i == RS_OPERATING) || (run_state_i == RS_LOAD);

  always_comb begin
    unique case (win_i)
      CL_SERV: enabled = en_ext_i;
      CL_IO:   enabled = en_io_i;
      CL_MCHK: enabled = en_mchk_i;
      default: enabled = 1'b0;
    endcase
  end

  assign kick_o = active && (!halted_i || enabled);

  // R4
  always_comb begin
    if (!active) inactive_no_kick_chk: assert (!kick_o);
  end
endmodule

// File: rtl/irq_wake_notifier.sv
module irq_wake_notifier
  import irq_wake_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 notify_i,
  input  logic [NUM_CLASS-1:0] class_i,
  input  logic [2*NUM_CPU-1:0] run_state_i,
  input  logic [NUM_CPU-1:0]   halted_i,
  input  logic [NUM_CPU-1:0]   en_ext_i,
  input  logic [NUM_CPU-1:0]   en_io_i,
  input  logic [NUM_CPU-1:0]   en_mchk_i,
  input  logic [NUM_CPU-1:0]   ack_i,
  output logic [NUM_CPU-1:0]   irq_req_o,
  output logic [NUM_CPU-1:0]   kick_o
);
  win_class_e         win;
  logic [NUM_CPU-1:0] kick_d;
  logic [NUM_CPU-1:0] req_q;
  logic [NUM_CPU-1:0] kick_q;

  irq_class_prio i_prio (
    .class_i (class_i),
    .win_o   (win)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    irq_cpu_filter i_filt (
      .win_i       (win),
      .run_state_i (run_state_i[2*c +: 2]),
      .halted_i    (halted_i[c]),
      .en_ext_i    (en_ext_i[c]),
      .en_io_i     (en_io_i[c]),
      .en_mchk_i   (en_mchk_i[c]),
      .kick_o      (kick_d[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      kick_q <= '0;
    end else begin
      // acknowledge takes precedence over a same-cycle notify
      req_q  <= (req_q | {NUM_CPU{notify_i}}) & ~ack_i;
      kick_q <= notify_i ? kick_d : '0;
    end
  end

  assign irq_req_o = req_q;
  assign kick_o    = kick_q;

  // R9
  kick_needs_notify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_o != '0) |-> $past(notify_i));

  // R2
  notify_sets_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notify_i && ack_i == '0) |=> (irq_req_o == '1));

  // R3
  ack_clears_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i == '1) |=> (irq_req_o == '0));

  // R3
  req_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!notify_i && ack_i == '0) |=> $stable(irq_req_o));
endmodule

// File: tb/test_irq_wake_notifier.sv
module test_irq_wake_notifier;
  localparam int unsigned NCPU  = 4;
  localparam time         T_CLK = 10ns;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            notify = 0;
  logic [2:0]      cls = '0;
  logic [2*NCPU-1:0] rs = '0;
  logic [NCPU-1:0] hlt = '0, eext = '0, eio = '0, emck = '0, ack = '0;
  logic [NCPU-1:0] req, kick;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(T_CLK/2) clk = ~clk;

  irq_wake_notifier #(.NUM_CPU(NCPU)) i_irq_wake_notifier (
    .clk_i(clk), .rst_ni(rst_n), .notify_i(notify), .class_i(cls),
    .run_state_i(rs), .halted_i(hlt), .en_ext_i(eext), .en_io_i(eio),
    .en_mchk_i(emck), .ack_i(ack), .irq_req_o(req), .kick_o(kick));

  task automatic chk(string rq, logic [NCPU-1:0] act, logic [NCPU-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", rq, act, exp);
    end
  endtask

  // strobe notify for one cycle; afterwards sample at mid-low phase
  task automatic pulse(logic [2:0] c);
    @(negedge clk); cls = c; notify = 1;
    @(negedge clk); notify = 0; cls = '0;
  endtask

  task automatic clear_all();
    @(negedge clk); ack = '1;
    @(negedge clk); ack = '0;
  endtask

  task automatic t_reset();
    chk("R1 req", req, '0);
    chk("R1 kick", kick, '0);
  endtask

  task automatic t_states();
    // cpu0 stopped, cpu1 checkstop, cpu2 operating, cpu3 load; none halted
    rs = {2'd3, 2'd2, 2'd1, 2'd0}; hlt = '0; eext = '0; eio = '0; emck = '0;
    pulse(3'b001);
    chk("R2 req all", req, 4'b1111);
    chk("R4/R5 kick", kick, 4'b1100);
    @(negedge clk);
    chk("R9 one cycle", kick, '0);
    chk("R3 sticky", req, 4'b1111);
    clear_all();
    chk("R3 ack clears", req, '0);
  endtask

  task automatic t_halted();
    rs = {4{2'd2}}; hlt = 4'b1111;
    eext = 4'b0001; eio = 4'b0010; emck = 4'b0100;
    pulse(3'b001); chk("R6 service", kick, 4'b0001);
    pulse(3'b010); chk("R7 io", kick, 4'b0010);
    pulse(3'b100); chk("R7 mchk", kick, 4'b0100);
    pulse(3'b110); chk("R8 io over mchk", kick, 4'b0010);
    pulse(3'b111); chk("R8 serv first", kick, 4'b0001);
    rs = {4{2'd3}}; hlt = 4'b0101;
    pulse(3'b000); chk("R10 zero class", kick, 4'b1010);
    chk("R10 req", req, 4'b1111);
    rs = {4{2'd0}}; hlt = '0; eext = '1;
    pulse(3'b001); chk("R4 stopped", kick, '0);
    clear_all();
  endtask

  task automatic t_ack();
    pulse(3'b010);
    @(negedge clk); ack = 4'b0011;
    @(negedge clk); ack = '0;
    chk("R3 partial ack", req, 4'b1100);
    @(negedge clk); ack = 4'b0100; cls = 3'b010; notify = 1;
    @(negedge clk); ack = '0; notify = 0; cls = '0;
    chk("R3 ack wins", req, 4'b1011);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_states();
    t_halted();
    t_ack();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule